// File: doc/BRIEF.md
# Tick-Driven Prioritized Task Scheduler

This block raises service requests for seven background tasks that run off a shared 1 ms tick. Each task has an enable, a tick counter and a fixed interval. When an enabled task has seen its interval's worth of ticks, it becomes pending. A dispatcher then hands exactly one request at a time to a consumer. The tasks themselves run outside the block.

The urgency of a task comes from its interval: the shorter the interval, the more urgent the task. Ties go to the lower task index. There is also an untimed event channel for a line-timeout condition. It needs no tick, and it wins over every tick-based task at the next grant decision.

The consumer sees a one-hot grant vector with a valid flag and answers with an acknowledge. The dispatcher is a two-state machine:
- `ST_IDLE` moves to `ST_GRANT` through the *select* transition when the event flag or any pending flag is set.
- `ST_GRANT` holds, through the *wait* transition, until `ack` arrives.
- `ST_GRANT` then returns to `ST_IDLE` through the *release* transition.

Tasks marked one-shot lose their enable when they are serviced.

Top module: `tick_task_sched`

## Requirements
- R1: After reset, `gnt_valid` is 0, `gnt` is all zeros, every enable, counter and pending flag is clear, and the event flag is clear.
- R2: An enabled task's counter advances by one on each cycle with `tick` high. A disabled task does not count. The pending flag of a task sets on the tick that brings its counter to its interval (default intervals 2, 3, 8, 9, 1, 255, 1 for tasks 0..6).
- R3: While a task is pending, its counter holds at the interval and does not wrap. Extra ticks do not create a second request.
- R4: Among pending tasks, the grant goes to the one with the smallest interval. Equal intervals go to the lower index, so the default order is 4, 6, 0, 1, 2, 3, 5.
- R5: `gnt` is one-hot while `gnt_valid` is high. Bit i of `gnt` is task i and bit 7 is the event. The grant stays unchanged until `ack`, and only one grant is outstanding at a time.
- R6: An `ack` while `gnt_valid` is high clears the granted task's pending flag and counter. The dispatcher spends one cycle in `ST_IDLE` before it can issue the next grant. A new grant appears in the cycle after a pending flag or event flag is seen in `ST_IDLE`.
- R7: Tasks marked one-shot (default: tasks 0 and 1) lose their enable when serviced, and they do not request again until they are re-enabled. The other tasks keep their enable.
- R8: A pulse on `evt_in` sets the event flag with no tick needed. The event is granted ahead of all pending tasks at the next selection. Its acknowledge clears the flag, unless a new `evt_in` arrives in the same cycle.
- R9: A disabled task's counter is 0, so setting an enable that was clear starts counting from 0. When `en_clr` and `en_set` are high for the same task in the same cycle, the clear wins.
- R10: An `ack` while `gnt_valid` is low has no effect on any task or on the event flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| en_set | input | 7 | Per-task enable set pulses |
| en_clr | input | 7 | Per-task enable clear pulses (win over set) |
| evt_in | input | 1 | Line-timeout event pulse |
| ack | input | 1 | Consumer acknowledge of the current grant |
| gnt_valid | output | 1 | A grant is outstanding |
| gnt | output | 8 | One-hot grant: bits 0..6 tasks, bit 7 event |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that the consumer only pulses `ack` as a response. A stray `ack` in `ST_IDLE` is legal and must be ignored. The assertions place no limit on how often enables are set or cleared, or on how often events arrive. The stimulus mixes directed sequences with seeded random cycles. In the random cycles, `tick`, `en_set`, `en_clr` and `evt_in` are sparse, and `ack` follows the grant about half the time. Occasional idle acks and simultaneous set/clear pulses cover the R9 and R10 corners.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } disp_state_t;
endpackage

// File: rtl/sched_slot.sv
`timescale 1ns/1ps
module sched_slot #(
    parameter int CW       = 8,
    parameter int IV       = 2,
    parameter bit ONE_SHOT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en_set,
    input  logic en_clr,
    input  logic svc,
    output logic pend
);
    localparam logic [CW-1:0] LAST = CW'(IV - 1);
    localparam logic [CW-1:0] TOP  = CW'(IV);

    logic          en_q, en_d, adv;
    logic [CW-1:0] cnt_q;

    always_comb begin
        if (en_clr || (svc && ONE_SHOT))
            en_d = 1'b0;
        else if (en_set)
            en_d = 1'b1;
        else
            en_d = en_q;
        adv = tick && en_q && en_d && !pend && !svc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
            pend  <= 1'b0;
        end else begin
            en_q <= en_d;
            if (!en_d || svc)
                cnt_q <= '0;
            else if (adv)
                cnt_q <= cnt_q + 1'b1;
            if (svc)
                pend <= 1'b0;
            else if (adv && cnt_q == LAST)
                pend <= 1'b1;
        end
    end

    // R3: counter never passes its interval
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    // R3: a request stays until serviced
    p_pend_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !svc |=> pend);
    // R2: request rises exactly with the counter at the interval
    p_pend_at_iv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> cnt_q == TOP);
    // R6: service clears request and counter
    p_svc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> !pend && cnt_q == '0);
    // R9: disabled task holds a zero count
    p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> cnt_q == '0);

    if (ONE_SHOT) begin : g_oneshot_chk
        // R7: one-shot task drops its enable on service
        p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
            svc |=> !en_q);
    end
endmodule

// File: rtl/sched_pick.sv
`timescale 1ns/1ps
module sched_pick #(
    parameter int                    NTASK = 7,
    parameter int                    CW    = 8,
    parameter logic [NTASK*CW-1:0]   IVALS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTASK-1:0] pend,
    output logic [NTASK-1:0] sel
);
    function automatic bit beats(int a, int b);
        logic [CW-1:0] va, vb;
        va = IVALS[a*CW +: CW];
        vb = IVALS[b*CW +: CW];
        return (va < vb) || ((va == vb) && (a < b));
    endfunction

    always_comb begin
        for (int i = 0; i < NTASK; i++) begin
            sel[i] = pend[i];
            for (int j = 0; j < NTASK; j++) begin
                if (j != i && pend[j] && beats(j, i))
                    sel[i] = 1'b0;
            end
        end
    end

    // R4: exactly one winner whenever something is pending
    p_pick_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> $countones(sel) == 1);
    // R4: the winner is itself pending
    p_pick_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel & ~pend) == '0);
endmodule

// File: rtl/sched_dispatch.sv
`timescale 1ns/1ps
module sched_dispatch
    import sched_pkg::*;
#(
    parameter int NTASK = 7,
    localparam int NG   = NTASK + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTASK-1:0] req,
    input  logic             evt_in,
    input  logic             ack,
    output logic             gnt_valid,
    output logic [NG-1:0]    gnt,
    output logic [NG-1:0]    svc
);
    disp_state_t st_q, st_d;
    logic        evt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (evt_q || (|req)) st_d = ST_GRANT;
            ST_GRANT: if (ack)             st_d = ST_IDLE;
            default:                       st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt   <= '0;
            evt_q <= 1'b0;
        end else begin
            if (evt_in)
                evt_q <= 1'b1;
            else if (svc[NTASK])
                evt_q <= 1'b0;
            unique case (st_q)
                ST_IDLE:  if (evt_q)      gnt <= {1'b1, {NTASK{1'b0}}};
                          else if (|req)  gnt <= {1'b0, req};
                ST_GRANT: if (ack)        gnt <= '0;
                default:                  gnt <= '0;
            endcase
        end
    end

    assign gnt_valid = (st_q == ST_GRANT);
    assign svc       = (gnt_valid && ack) ? gnt : '0;

    // R5: grant is one-hot while valid
    p_gnt_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $countones(gnt) == 1);
    // R5: grant held until acknowledged
    p_gnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid && !ack |=> gnt_valid && $stable(gnt));
    // R6: acknowledge releases the grant for one idle cycle
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid && ack |=> !gnt_valid);
    // R8: a waiting event wins the next selection
    p_evt_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid && evt_q |=> gnt[NTASK]);
    // R8: servicing the event clears its flag
    p_evt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        svc[NTASK] && !evt_in |=> !evt_q);
endmodule

// File: rtl/tick_task_sched.sv
`timescale 1ns/1ps
module tick_task_sched #(
    parameter int                  NTASK   = 7,
    parameter int                  CW      = 8,
    parameter logic [NTASK*CW-1:0] IVALS   = {8'd1, 8'd255, 8'd1, 8'd9, 8'd8, 8'd3, 8'd2},
    parameter logic [NTASK-1:0]    ONESHOT = 7'b0000011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NTASK-1:0] en_set,
    input  logic [NTASK-1:0] en_clr,
    input  logic             evt_in,
    input  logic             ack,
    output logic             gnt_valid,
    output logic [NTASK:0]   gnt
);
    logic [NTASK-1:0] pend, sel;
    logic [NTASK:0]   svc;

    for (genvar i = 0; i < NTASK; i++) begin : g_slot
        sched_slot #(
            .CW      (CW),
            .IV      (int'(IVALS[i*CW +: CW])),
            .ONE_SHOT(ONESHOT[i])
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .en_set(en_set[i]),
            .en_clr(en_clr[i]),
            .svc   (svc[i]),
            .pend  (pend[i])
        );
    end

    sched_pick #(.NTASK(NTASK), .CW(CW), .IVALS(IVALS)) u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .pend (pend),
        .sel  (sel)
    );

    sched_dispatch #(.NTASK(NTASK)) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (sel),
        .evt_in   (evt_in),
        .ack      (ack),
        .gnt_valid(gnt_valid),
        .gnt      (gnt),
        .svc      (svc)
    );

    // R10: no service without an outstanding grant
    p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |=> $stable(pend) || !$past(ack) || (|$past(en_clr)) || $past(tick));
endmodule

// File: tb/tb_tick_task_sched.sv
`timescale 1ns/1ps
module tb_tick_task_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, evt_in = 1'b0, ack = 1'b0;
    logic [6:0] en_set = '0, en_clr = '0;
    logic       gnt_valid;
    logic [7:0] gnt;

    always #2 clk = ~clk;

    tick_task_sched dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en_set(en_set), .en_clr(en_clr),
        .evt_in(evt_in), .ack(ack), .gnt_valid(gnt_valid), .gnt(gnt)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    const int IV[7] = '{2, 3, 8, 9, 1, 255, 1};
    const bit OS[7] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    bit         m_en[7], m_pend[7];
    int         m_cnt[7];
    bit         m_evt, m_valid;
    logic [7:0] m_gnt;

    function automatic logic [7:0] pick();
        int best = -1;
        if (m_evt) return 8'h80;
        for (int i = 0; i < 7; i++)
            if (m_pend[i] && (best < 0 || IV[i] < IV[best])) best = i;
        return (best < 0) ? 8'h00 : 8'(1 << best);
    endfunction

    task automatic step_model(input bit t, input logic [6:0] s, input logic [6:0] c,
                              input bit e, input bit a);
        logic [7:0] svc = (m_valid && a) ? m_gnt : 8'h00;
        logic [7:0] sel = pick();
        bit any = 0;
        for (int i = 0; i < 7; i++) any |= m_pend[i];
        for (int i = 0; i < 7; i++) begin
            bit en_n = (c[i] || (svc[i] && OS[i])) ? 1'b0 : (s[i] ? 1'b1 : m_en[i]);
            bit adv = t && m_en[i] && en_n && !m_pend[i] && !svc[i];
            if (svc[i]) m_pend[i] = 0;
            else if (adv && m_cnt[i] + 1 == IV[i]) m_pend[i] = 1;
            if (!en_n || svc[i]) m_cnt[i] = 0;
            else if (adv) m_cnt[i] = m_cnt[i] + 1;
            m_en[i] = en_n;
        end
        if (!m_valid) begin
            if (m_evt || any) begin m_valid = 1; m_gnt = sel; end
        end else if (a) begin
            m_valid = 0; m_gnt = 8'h00;
        end
        if (e) m_evt = 1;
        else if (svc[7]) m_evt = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit t, input logic [6:0] s, input logic [6:0] c,
                       input bit e, input bit a, input string tag);
        tick = t; en_set = s; en_clr = c; evt_in = e; ack = a;
        step_model(t, s, c, e, a);
        @(posedge clk);
        @(negedge clk);
        tick = 0; en_set = '0; en_clr = '0; evt_in = 0; ack = 0;
        chk(gnt_valid == m_valid && gnt == m_gnt, tag, {gnt_valid, gnt}, {m_valid, m_gnt});
    endtask

    task automatic expect_gnt(input logic [7:0] exp, input string tag);
        chk(gnt_valid == (exp != 0) && gnt == exp, tag, {gnt_valid, gnt}, {exp != 0, exp});
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 20 && m_valid; k++) begin
            cyc(0, '0, '0, 0, 1, tag);
            cyc(0, '0, '0, 0, 0, tag);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 7; i++) begin m_en[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; end
        m_evt = 0; m_valid = 0; m_gnt = 0;
        repeat (3) @(negedge clk);
        expect_gnt(8'h00, "R1 reset state");
        rst_n = 1;
        cyc(0, '0, '0, 0, 0, "R1 idle after reset");
        cyc(1, '0, '0, 0, 0, "R2 tick with nothing enabled");
        cyc(0, '0, '0, 0, 1, "R10 ack while idle");
        expect_gnt(8'h00, "R10 idle ack no grant");

        // R2: task 4 (interval 1) requests on its first tick
        cyc(0, 7'h10, '0, 0, 0, "R2 enable task4");
        cyc(1, '0, '0, 0, 0, "R2 first tick");
        cyc(0, '0, '0, 0, 0, "R2 grant latency");
        expect_gnt(8'h10, "R2 task4 granted");
        cyc(0, '0, '0, 0, 1, "R6 ack task4");
        expect_gnt(8'h00, "R6 idle after ack");
        cyc(0, '0, 7'h10, 0, 0, "R9 disable task4");

        // R3/R4: everything pending, no acks during 255 ticks
        cyc(0, 7'h7F, '0, 0, 0, "R4 enable all");
        for (int k = 0; k < 260; k++) cyc(1, '0, '0, 0, 0, "R3 ticks while pending");
        expect_gnt(8'h10, "R4 shortest interval first");
        cyc(0, '0, '0, 1, 0, "R8 event while granted");
        expect_gnt(8'h10, "R5 grant held over event");
        cyc(0, '0, '0, 0, 1, "R6 ack");
        cyc(0, '0, '0, 0, 0, "R8 select");
        expect_gnt(8'h80, "R8 event preempts tasks");
        cyc(0, '0, '0, 0, 1, "R8 ack event");
        begin
            logic [7:0] order[6] = '{8'h40, 8'h01, 8'h02, 8'h04, 8'h08, 8'h20};
            for (int k = 0; k < 6; k++) begin
                cyc(0, '0, '0, 0, 0, "R4 select");
                expect_gnt(order[k], "R4 priority order");
                cyc(0, '0, '0, 0, 1, "R6 ack in order");
            end
        end
        cyc(0, '0, '0, 0, 0, "R8 flag cleared");
        expect_gnt(8'h00, "R8 no repeat event");

        // R7: one-shot tasks 0 and 1 stay silent
        for (int k = 0; k < 5; k++) cyc(1, '0, '0, 0, 0, "R7 ticks after one-shot");
        expect_gnt(8'h10, "R7 periodic task requests again");
        drain("R7 drain");
        expect_gnt(8'h00, "R7 one-shot tasks silent");

        // R9: clear beats set, restart from zero
        cyc(0, '0, 7'h7F, 0, 0, "R9 clear all");
        drain("R9 drain");
        cyc(0, 7'h04, 7'h04, 0, 0, "R9 set and clear together");
        for (int k = 0; k < 10; k++) cyc(1, '0, '0, 0, 0, "R9 ticks while off");
        expect_gnt(8'h00, "R9 clear wins");
        cyc(0, 7'h04, '0, 0, 0, "R9 enable task2");
        for (int k = 0; k < 7; k++) cyc(1, '0, '0, 0, 0, "R9 count from zero");
        cyc(0, '0, '0, 0, 0, "R9 not yet");
        expect_gnt(8'h00, "R9 seven ticks not enough");
        cyc(1, '0, '0, 0, 0, "R2 eighth tick");
        cyc(0, '0, '0, 0, 0, "R2 latency");
        expect_gnt(8'h04, "R2 task2 at interval");
        drain("R6 drain");

        // Random phase
        for (int k = 0; k < 5000; k++) begin
            bit t = ($urandom % 3) == 0;
            logic [6:0] s = (($urandom % 6) == 0) ? 7'($urandom) : 7'h00;
            logic [6:0] c = (($urandom % 12) == 0) ? 7'($urandom) : 7'h00;
            bit e = ($urandom % 40) == 0;
            bit a = m_valid ? (($urandom % 2) == 0) : (($urandom % 8) == 0);
            cyc(t, s, c, e, a, "R5 random mix");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule